// File: doc/BRIEF.md
# Speculative Indirect Path History Buffer

This block keeps, for one hardware thread, an ordered list of the indirect branches the front end has predicted but not yet retired, along with a small number of retired ones. Each slot holds the branch address, the predicted target and a 16-bit sequence number. An indirect target predictor reads the newest targets from the block, newest first, and folds them into its set index. After a misprediction it reads a second window that leaves out the youngest branch, so that it can rebuild the index that branch was predicted with.

The pipeline drives four operations. A prediction appends a slot at the young end. A retire message carrying a sequence number advances a counter of retained retired slots by at most one step. Once that counter has reached the path length, the step instead drops the oldest slot. A flush message cuts every slot younger than a sequence number. A correction overwrites the target of the youngest slot in place. Several threads use several instances.

Top module: `path_hist_buf`

## Requirements
- R1: After reset the buffer is empty. The retained-retired counter is 0, the overflow flag is 0, both target windows and their lengths are 0, and the youngest-valid output is 0.
- R2: A record adds (address, target, sequence) as the new youngest slot. From the next cycle the youngest-address output shows that address and the occupancy has grown by one.
- R3: The main window lists the targets newest first, slot 0 being the youngest. Its length is the smaller of PATH_LEN (default 3) and the occupancy, and unused slots read 0.
- R4: A retire with sequence S increments the counter by one when the buffer is nonempty, the counter is below both the occupancy and PATH_LEN, and the slot at counter position (0 = oldest) has sequence ≤ S. Occupancy is unchanged.
- R5: When the counter is already PATH_LEN and the other conditions of R4 hold, a retire removes the oldest slot and leaves the counter at PATH_LEN.
- R6: A retire changes nothing in three cases: the slot at counter position has sequence > S, the counter is not below the occupancy, or the buffer is empty.
- R7: A flush with sequence S finds the oldest slot whose sequence is greater than S, compared unsigned. It removes that slot and every younger one, and older slots are kept. The counter is not altered.
- R8: A correction replaces the target of the youngest slot, which stays youngest, and occupancy is unchanged. On an empty buffer a correction changes nothing.
- R9: The recovery window is the main window with the youngest slot skipped. Its length is the smaller of PATH_LEN and occupancy−1, floored at 0, and unused slots read 0.
- R10: A record into a full buffer (DEPTH slots, default 16) is dropped and sets the overflow flag. The flag stays set until reset.
- R11: When operations share a cycle they take effect in this order: flush first, then correction, then retire, then record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid_i | input | 1 | Record a predicted indirect branch |
| rec_addr_i | input | ADDR_W | Branch address to record |
| rec_tgt_i | input | ADDR_W | Predicted target to record |
| rec_seq_i | input | SEQ_W | Sequence number of the recorded branch |
| ret_valid_i | input | 1 | Retire request |
| ret_seq_i | input | SEQ_W | Retire sequence bound |
| fl_valid_i | input | 1 | Flush request |
| fl_seq_i | input | SEQ_W | Flush bound; strictly younger slots are removed |
| fix_valid_i | input | 1 | Correct the youngest slot's target |
| fix_tgt_i | input | ADDR_W | Corrected target |
| win_tgt_o | output | PATH_LEN x ADDR_W | Newest-first target window |
| win_len_o | output | LEN_W | Valid slots in the main window |
| rcv_tgt_o | output | PATH_LEN x ADDR_W | Window with the youngest slot skipped |
| rcv_len_o | output | LEN_W | Valid slots in the recovery window |
| young_vld_o | output | 1 | Buffer is nonempty |
| young_addr_o | output | ADDR_W | Branch address of the youngest slot, 0 when empty |
| occ_o | output | OCC_W | Occupied slots |
| kept_o | output | KEPT_W | Retained-retired counter |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A misplaced flush cut shows up one cycle later in three places: a wrong occupancy, a youngest address from a slot that should be gone, and a window that lists stale targets. A bad retire step shows immediately in the counter output, or in the occupancy when a drop goes wrong. It only later skews which slot the next retire inspects, so later retires drift from the model. A correction written to the wrong slot is visible in both windows the cycle after. Because the windows and the youngest address are compared every cycle, a corrupted slot cannot stay hidden for more than the cycles it spends outside the newest PATH_LEN+1 positions.

// File: rtl/phb_pkg.sv
package phb_pkg;

    // Number of valid window slots when SKIP youngest slots are left out.
    function automatic int unsigned window_len(input int unsigned occ,
                                               input int unsigned skip,
                                               input int unsigned plen);
        int unsigned avail;
        if (occ <= skip) begin
            return 0;
        end
        avail = occ - skip;
        return (avail < plen) ? avail : plen;
    endfunction

endpackage

// File: rtl/phb_flush_cut.sv
// Finds the oldest occupied slot whose sequence number exceeds the bound.
// Returns the occupancy itself when no such slot exists.
module phb_flush_cut #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned SEQ_W = 16,
    localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq_i,
    input  logic [OCC_W-1:0]            occ_i,
    input  logic [SEQ_W-1:0]            bound_i,
    output logic [OCC_W-1:0]            cut_o
);

    logic [DEPTH-1:0] younger;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
            assign younger[i] = (OCC_W'(i) < occ_i) && (seq_i[i] > bound_i);
        end
    endgenerate

    always_comb begin
        cut_o = occ_i;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (younger[i]) begin
                cut_o = OCC_W'(i);
            end
        end
    end

endmodule

// File: rtl/phb_window.sv
// Newest-first target window; SKIP youngest slots are left out.
module phb_window #(
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned PATH_LEN = 3,
    parameter int unsigned SKIP     = 0,
    localparam int unsigned OCC_W   = $clog2(DEPTH + 1),
    localparam int unsigned IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LEN_W   = $clog2(PATH_LEN + 1)
) (
    input  logic [DEPTH-1:0][ADDR_W-1:0]    tgt_i,
    input  logic [OCC_W-1:0]                occ_i,
    output logic [PATH_LEN-1:0][ADDR_W-1:0] win_o,
    output logic [LEN_W-1:0]                len_o
);

    import phb_pkg::*;

    generate
        for (genvar p = 0; p < PATH_LEN; p++) begin : g_slot
            always_comb begin
                if (int'(occ_i) > int'(SKIP + p)) begin
                    win_o[p] = tgt_i[IDX_W'(int'(occ_i) - 1 - int'(SKIP) - p)];
                end else begin
                    win_o[p] = '0;
                end
            end
        end
    endgenerate

    assign len_o = LEN_W'(window_len(int'(occ_i), SKIP, PATH_LEN));

endmodule

// File: rtl/path_hist_buf.sv
module path_hist_buf #(
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned SEQ_W    = 16,
    parameter int unsigned PATH_LEN = 3,
    localparam int unsigned OCC_W   = $clog2(DEPTH + 1),
    localparam int unsigned IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LEN_W   = $clog2(PATH_LEN + 1),
    localparam int unsigned KEPT_W  = $clog2(PATH_LEN + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rec_valid_i,
    input  logic [ADDR_W-1:0]              rec_addr_i,
    input  logic [ADDR_W-1:0]              rec_tgt_i,
    input  logic [SEQ_W-1:0]               rec_seq_i,
    input  logic                           ret_valid_i,
    input  logic [SEQ_W-1:0]               ret_seq_i,
    input  logic                           fl_valid_i,
    input  logic [SEQ_W-1:0]               fl_seq_i,
    input  logic                           fix_valid_i,
    input  logic [ADDR_W-1:0]              fix_tgt_i,
    output logic [PATH_LEN-1:0][ADDR_W-1:0] win_tgt_o,
    output logic [LEN_W-1:0]               win_len_o,
    output logic [PATH_LEN-1:0][ADDR_W-1:0] rcv_tgt_o,
    output logic [LEN_W-1:0]               rcv_len_o,
    output logic                           young_vld_o,
    output logic [ADDR_W-1:0]              young_addr_o,
    output logic [OCC_W-1:0]               occ_o,
    output logic [KEPT_W-1:0]              kept_o,
    output logic                           ovf_o
);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][ADDR_W-1:0] tgt;
        logic [DEPTH-1:0][SEQ_W-1:0]  seq;
        logic [OCC_W-1:0]             occ;
        logic [KEPT_W-1:0]            kept;
        logic                         ovf;
    } phb_state_t;

    phb_state_t st_d, st_q;
    logic [OCC_W-1:0] cut;

    // Flush cut point from the registered slots
    phb_flush_cut #(
        .DEPTH (DEPTH),
        .SEQ_W (SEQ_W)
    ) i_cut (
        .seq_i   (st_q.seq),
        .occ_i   (st_q.occ),
        .bound_i (fl_seq_i),
        .cut_o   (cut)
    );

    // Next state: flush, correction, retire, record, in that order
    always_comb begin
        logic [OCC_W-1:0] occ_v;
        logic             can_ret;
        st_d  = st_q;
        occ_v = st_q.occ;

        if (fl_valid_i) begin
            occ_v = cut;
        end

        if (fix_valid_i && (occ_v != '0)) begin
            st_d.tgt[IDX_W'(occ_v - 1'b1)] = fix_tgt_i;
        end

        can_ret = ret_valid_i && (occ_v != '0) &&
                  (OCC_W'(st_d.kept) < occ_v) &&
                  (st_d.seq[IDX_W'(st_d.kept)] <= ret_seq_i);
        if (can_ret) begin
            if (int'(st_d.kept) >= int'(PATH_LEN)) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    st_d.addr[i] = st_d.addr[i+1];
                    st_d.tgt[i]  = st_d.tgt[i+1];
                    st_d.seq[i]  = st_d.seq[i+1];
                end
                occ_v = occ_v - 1'b1;
            end else begin
                st_d.kept = st_d.kept + 1'b1;
            end
        end

        if (rec_valid_i) begin
            if (occ_v < OCC_W'(DEPTH)) begin
                st_d.addr[IDX_W'(occ_v)] = rec_addr_i;
                st_d.tgt[IDX_W'(occ_v)]  = rec_tgt_i;
                st_d.seq[IDX_W'(occ_v)]  = rec_seq_i;
                occ_v = occ_v + 1'b1;
            end else begin
                st_d.ovf = 1'b1;
            end
        end

        st_d.occ = occ_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Hashing windows
    phb_window #(
        .DEPTH    (DEPTH),
        .ADDR_W   (ADDR_W),
        .PATH_LEN (PATH_LEN),
        .SKIP     (0)
    ) i_win_main (
        .tgt_i (st_q.tgt),
        .occ_i (st_q.occ),
        .win_o (win_tgt_o),
        .len_o (win_len_o)
    );

    phb_window #(
        .DEPTH    (DEPTH),
        .ADDR_W   (ADDR_W),
        .PATH_LEN (PATH_LEN),
        .SKIP     (1)
    ) i_win_rcv (
        .tgt_i (st_q.tgt),
        .occ_i (st_q.occ),
        .win_o (rcv_tgt_o),
        .len_o (rcv_len_o)
    );

    assign young_vld_o  = (st_q.occ != '0);
    assign young_addr_o = young_vld_o ? st_q.addr[IDX_W'(st_q.occ - 1'b1)] : '0;
    assign occ_o        = st_q.occ;
    assign kept_o       = st_q.kept;
    assign ovf_o        = st_q.ovf;

    AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.occ) <= int'(DEPTH)); // R10
    AST_KEPT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.kept) <= int'(PATH_LEN)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf); // R10
    AST_RECORD_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_i && !fl_valid_i && !ret_valid_i && (int'(st_q.occ) < int'(DEPTH)))
        |=> (st_q.occ == $past(st_q.occ) + 1'b1)); // R2
    AST_FLUSH_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid_i && !rec_valid_i) |=> (st_q.occ <= $past(st_q.occ))); // R7
    AST_FIX_KEEPS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_valid_i && !fl_valid_i && !ret_valid_i && !rec_valid_i)
        |=> $stable(st_q.occ)); // R8
    AST_RETIRE_BELOW_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_i && !fl_valid_i && !rec_valid_i && (int'(st_q.kept) < int'(PATH_LEN)))
        |=> $stable(st_q.occ)); // R4
    AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.occ == '0) |-> (win_len_o == '0 && rcv_len_o == '0)); // R3

endmodule

// File: tb/test_path_hist_buf.sv
module test_path_hist_buf;

    localparam int DEPTH = 16;
    localparam int AW    = 32;
    localparam int SW    = 16;
    localparam int PL    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rec_valid = 0, ret_valid = 0, fl_valid = 0, fix_valid = 0;
    logic [AW-1:0] rec_addr = '0, rec_tgt = '0, fix_tgt = '0;
    logic [SW-1:0] rec_seq = '0, ret_seq = '0, fl_seq = '0;
    logic [PL-1:0][AW-1:0] win_tgt, rcv_tgt;
    logic [1:0] win_len, rcv_len;
    logic young_vld, ovf;
    logic [AW-1:0] young_addr;
    logic [4:0] occ;
    logic [1:0] kept;

    always #10 clk = ~clk;

    path_hist_buf i_path_hist_buf (
        .clk (clk), .rst_n (rst_n),
        .rec_valid_i (rec_valid), .rec_addr_i (rec_addr), .rec_tgt_i (rec_tgt), .rec_seq_i (rec_seq),
        .ret_valid_i (ret_valid), .ret_seq_i (ret_seq),
        .fl_valid_i (fl_valid), .fl_seq_i (fl_seq),
        .fix_valid_i (fix_valid), .fix_tgt_i (fix_tgt),
        .win_tgt_o (win_tgt), .win_len_o (win_len),
        .rcv_tgt_o (rcv_tgt), .rcv_len_o (rcv_len),
        .young_vld_o (young_vld), .young_addr_o (young_addr),
        .occ_o (occ), .kept_o (kept), .ovf_o (ovf)
    );

    typedef struct { logic [AW-1:0] a; logic [AW-1:0] t; logic [SW-1:0] s; } ent_t;
    ent_t mq[$];
    int   m_kept;
    bit   m_ovf;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        int n;
        n = mq.size();
        chk(req, "occ", occ, n);
        chk(req, "kept", kept, m_kept);
        chk(req, "ovf", ovf, m_ovf);
        chk(req, "young_vld", young_vld, n > 0);
        chk(req, "young_addr", young_addr, (n > 0) ? mq[n-1].a : 0);
        chk(req, "win_len", win_len, (n < PL) ? n : PL);
        chk(req, "rcv_len", rcv_len, (n <= 1) ? 0 : ((n - 1 < PL) ? n - 1 : PL));
        for (int p = 0; p < PL; p++) begin
            chk(req, $sformatf("win[%0d]", p), win_tgt[p], (n > p) ? mq[n-1-p].t : 0);
            chk(req, $sformatf("rcv[%0d]", p), rcv_tgt[p], (n > p + 1) ? mq[n-2-p].t : 0);
        end
    endtask

    task automatic model_step(input bit fl, input logic [SW-1:0] fs, input bit fx,
                              input logic [AW-1:0] ft, input bit rt, input logic [SW-1:0] rs,
                              input bit rc, input logic [AW-1:0] ra, input logic [AW-1:0] rtg,
                              input logic [SW-1:0] rsq);
        if (fl) begin
            int cutp;
            cutp = mq.size();
            for (int i = 0; i < mq.size(); i++) begin
                if (mq[i].s > fs) begin cutp = i; break; end
            end
            while (mq.size() > cutp) void'(mq.pop_back());
        end
        if (fx && mq.size() > 0) mq[mq.size()-1].t = ft;
        if (rt && mq.size() > 0 && m_kept < mq.size() && mq[m_kept].s <= rs) begin
            if (m_kept >= PL) void'(mq.pop_front());
            else m_kept++;
        end
        if (rc) begin
            if (mq.size() < DEPTH) begin
                ent_t e;
                e.a = ra; e.t = rtg; e.s = rsq;
                mq.push_back(e);
            end else m_ovf = 1;
        end
    endtask

    // Called at a falling edge: drive, take the rising edge, compare at next falling edge
    task automatic step(input string req, input bit fl, input logic [SW-1:0] fs, input bit fx,
                        input logic [AW-1:0] ft, input bit rt, input logic [SW-1:0] rs,
                        input bit rc, input logic [AW-1:0] ra, input logic [AW-1:0] rtg,
                        input logic [SW-1:0] rsq);
        fl_valid = fl; fl_seq = fs; fix_valid = fx; fix_tgt = ft;
        ret_valid = rt; ret_seq = rs; rec_valid = rc; rec_addr = ra; rec_tgt = rtg; rec_seq = rsq;
        @(posedge clk);
        model_step(fl, fs, fx, ft, rt, rs, rc, ra, rtg, rsq);
        @(negedge clk);
        fl_valid = 0; fix_valid = 0; ret_valid = 0; rec_valid = 0;
        compare(req);
    endtask

    task automatic record(input string req, input logic [AW-1:0] a, input logic [AW-1:0] t, input logic [SW-1:0] s);
        step(req, 0, 0, 0, 0, 0, 0, 1, a, t, s);
    endtask

    task automatic retire(input string req, input logic [SW-1:0] s);
        step(req, 0, 0, 0, 0, 1, s, 0, 0, 0, 0);
    endtask

    task automatic flush(input string req, input logic [SW-1:0] s);
        step(req, 1, s, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic fix(input string req, input logic [AW-1:0] t);
        step(req, 0, 0, 1, t, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(posedge clk);
        mq.delete(); m_kept = 0; m_ovf = 0;
        @(negedge clk);
        rst_n = 1;
        compare("R1");
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R2 R3 R9: fill five slots and watch both windows grow
        for (int i = 0; i < 5; i++)
            record("R2", 32'h1000 + i * 4, 32'h8000 + i * 32'h40, 16'(10 + i));
        chk("R3", "win[0] newest", win_tgt[0], 32'h8100);
        chk("R9", "rcv[0] second youngest", rcv_tgt[0], 32'h80C0);

        // R6: head slot seq 10 is above bound 5
        retire("R6", 16'd5);
        // R4: three steps up to the path length
        retire("R4", 16'd20);
        retire("R4", 16'd20);
        retire("R4", 16'd20);
        chk("R4", "kept at path length", kept, PL);
        // R5: further retires drop the oldest
        retire("R5", 16'd20);
        retire("R5", 16'd20);
        chk("R5", "occ after drops", occ, 3);
        // R6: counter not below occupancy
        retire("R6", 16'd20);

        // R7: flush younger than 21
        for (int i = 0; i < 4; i++)
            record("R2", 32'h2000 + i * 4, 32'h9000 + i * 32'h10, 16'(20 + i));
        flush("R7", 16'd21);
        chk("R7", "young addr after flush", young_addr, 32'h2004);

        // R8: correction of youngest target
        fix("R8", 32'h000DEAD0);
        chk("R8", "corrected target", win_tgt[0], 32'h000DEAD0);

        // R10: fill and overflow
        for (int i = 0; i < 13; i++)
            record("R10", 32'h3000 + i * 4, 32'hA000 + i * 32'h8, 16'(30 + i));
        chk("R10", "ovf set", ovf, 1);
        flush("R10", 16'd35);
        chk("R10", "ovf sticky", ovf, 1);

        // R7: flush everything, then R6 R8 on empty buffer
        flush("R7", 16'd0);
        chk("R7", "empty after flush", occ, 0);
        fix("R8", 32'h1234);
        retire("R6", 16'hFFFF);

        // R11: all four operations in one cycle
        do_reset();
        record("R2", 32'h4000, 32'hB000, 16'd50);
        record("R2", 32'h4004, 32'hB100, 16'd51);
        record("R2", 32'h4008, 32'hB200, 16'd52);
        step("R11", 1, 16'd51, 1, 32'hC000, 1, 16'd50, 1, 32'h400C, 32'hB300, 16'd60);
        chk("R11", "occ after combined", occ, 3);
        chk("R11", "corrected second slot", rcv_tgt[0], 32'hC000);
        step("R11", 1, 16'd50, 0, 0, 1, 16'd60, 1, 32'h4010, 32'hB400, 16'd61);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule